// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Controller

This block is the buffering and event core that sits beside a serial shift engine. It holds one FIFO for words to be sent and one for words received. A register port lets software fill the send side, drain the receive side, read the fill levels, and set up which events raise the shared interrupt line. The shift engine takes words from the send FIFO, pushes received words into the receive FIFO, and reports when shifting and transfers finish.

Software writes a word to the transmit window register to push it. A read of the receive window register pops the oldest received word. Writing zero to a level register empties that FIFO. The receive trigger compares the receive level against a power-of-two threshold and fires only while its own enable is set. There are six event sources. Each one latches into a write-one-to-clear status bit, and each has a matching enable bit at the same position in the control register. A soft reset bit in the control register holds the engine idle and clears all of the block's state.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each FIFO holds DEPTH words (32 by default). A word that the engine pushes while the receive FIFO is full is discarded, and status bit 12 (overflow) is set.
- R2: Reading RX_LVL (address 2) or TX_LVL (address 3) returns the current fill count. Writing 0 to either one empties that FIFO. Writing a nonzero value has no effect.
- R3: Status bit 0 is set in every cycle in which control bit 19 is 1 and the receive level is at least 2^n, where n is bits [2:0] of TRIG (address 6). It is never set while control bit 19 is 0.
- R4: STAT (address 1) holds events at bits 0, 4, 8, 9, 12 and 13. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R5: When the engine requests a word (tx_pop_i) while the transmit FIFO is empty, status bit 13 (underrun) is set and the level stays 0.
- R6: An engine pop that leaves the transmit level at or below DEPTH/2 sets status bit 4.
- R7: tx_done_i while the transmit level is 0 sets status bit 9. xfer_end_i sets status bit 8.
- R8: irq_o is high exactly when some status bit is 1 and the control bit at the same position is also 1.
- R9: While control bit 28 is 1: core_hold_o is high, the busy bit (bit 16 of a STAT read) reads 0, both FIFOs are empty, all status bits are clear, and pushes from either side are ignored.
- R10: Both FIFOs are first-in first-out. A write to TXWIN (address 5) pushes a word, and tx_word_o shows the oldest word. A read of RXWIN (address 4) returns the oldest word and pops it. A read of RXWIN while the receive FIFO is empty returns 0.
- R11: After reset, all registers read 0, irq_o is low, tx_empty_o is high and core_hold_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (pops RXWIN) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tx_pop_i | input | 1 | Engine takes the oldest transmit word |
| tx_word_o | output | W | Oldest transmit word |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_done_i | input | 1 | Engine finished shifting a word |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_word_i | input | W | Received word |
| xfer_end_i | input | 1 | Engine signals end of transfer |
| busy_i | input | 1 | Engine busy indication |
| core_hold_o | output | 1 | Holds the engine idle (soft reset) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with W = 16 and the default DEPTH = 32. With a 32-entry FIFO, 33 engine pushes reach the overflow boundary. The transmit trigger threshold at level 17 is reached with a short burst of pops. A receive trigger field of 2 gives a 4-word threshold, so the point where the trigger fires can be checked with a few words. Every clock, a queue-based model is compared against the interrupt line, the transmit head and empty flag, the hold output, and every register read.

// File: rtl/spi_fi_pkg.sv
package spi_fi_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_RXLVL = 3'd2,
    REG_TXLVL = 3'd3,
    REG_RXWIN = 3'd4,
    REG_TXWIN = 3'd5,
    REG_TRIG  = 3'd6
  } reg_addr_e;

  localparam int unsigned BIT_RXTRG   = 0;
  localparam int unsigned BIT_TXTRG   = 4;
  localparam int unsigned BIT_XEND    = 8;
  localparam int unsigned BIT_TXEMPTY = 9;
  localparam int unsigned BIT_OVF     = 12;
  localparam int unsigned BIT_UNF     = 13;
  localparam int unsigned BIT_BUSY    = 16;
  localparam int unsigned BIT_RXTEN   = 19;
  localparam int unsigned BIT_SRST    = 28;

  localparam int unsigned STAT_W = 14;
  localparam logic [STAT_W-1:0] STAT_MASK = 14'h3311;
  localparam logic [31:0] CTRL_MASK = 32'h1008_3311;
endpackage

// File: rtl/spi_fi_fifo.sv
module spi_fi_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wp_q] <= data_i;
  end

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r1_full_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o);
  a_r2_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_fi_irq.sv
module spi_fi_irq
  import spi_fi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] w1c_i,
  input  logic [STAT_W-1:0] en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= '0;
    else if (clr_all_i) stat_q <= '0;
    else                stat_q <= ((stat_q & ~w1c_i) | evt_i) & STAT_MASK;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);

  a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_all_i && (|(w1c_i & ~evt_i)) |=> ((stat_o & $past(w1c_i & ~evt_i)) == '0));
  a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_all_i && (|(evt_i & STAT_MASK)) |=>
      ((stat_o & $past(evt_i & STAT_MASK)) == $past(evt_i & STAT_MASK)));
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fi_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         re_i,
  input  logic [2:0]   addr_i,
  input  logic [31:0]  wdata_i,
  output logic [31:0]  rdata_o,
  input  logic         tx_pop_i,
  output logic [W-1:0] tx_word_o,
  output logic         tx_empty_o,
  input  logic         tx_done_i,
  input  logic         rx_push_i,
  input  logic [W-1:0] rx_word_i,
  input  logic         xfer_end_i,
  input  logic         busy_i,
  output logic         core_hold_o,
  output logic         irq_o
);
  logic [31:0]       ctrl_q;
  logic [2:0]        trig_q;
  logic              srst;
  logic [STAT_W-1:0] stat, evt, w1c;
  logic [W-1:0]      rx_head;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              rx_full, rx_empty, tx_full;
  logic              wr_ctrl, wr_stat, wr_trig, wr_txwin, rd_rxwin;
  logic              rx_flush, tx_flush, tx_pop_ok, rx_trg_hit;

  assign srst        = ctrl_q[BIT_SRST];
  assign core_hold_o = srst;
  assign wr_ctrl  = we_i && addr_i == REG_CTRL;
  assign wr_stat  = we_i && addr_i == REG_STAT;
  assign wr_trig  = we_i && addr_i == REG_TRIG;
  assign wr_txwin = we_i && addr_i == REG_TXWIN && !srst;
  assign rd_rxwin = re_i && addr_i == REG_RXWIN && !srst;
  assign rx_flush = srst || (we_i && addr_i == REG_RXLVL && wdata_i == '0);
  assign tx_flush = srst || (we_i && addr_i == REG_TXLVL && wdata_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      trig_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_trig) trig_q <= wdata_i[2:0];
    end
  end

  spi_fi_fifo #(.W(W), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni, .flush_i(rx_flush),
    .push_i(rx_push_i && !srst), .data_i(rx_word_i), .pop_i(rd_rxwin),
    .head_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_fi_fifo #(.W(W), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni, .flush_i(tx_flush),
    .push_i(wr_txwin), .data_i(wdata_i[W-1:0]), .pop_i(tx_pop_i && !srst),
    .head_o(tx_word_o), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty_o)
  );

  assign tx_pop_ok  = tx_pop_i && !tx_empty_o;
  assign rx_trg_hit = ctrl_q[BIT_RXTEN] && (32'(rx_cnt) >= (32'd1 << trig_q));

  always_comb begin
    evt = '0;
    if (!srst) begin
      evt[BIT_RXTRG]   = rx_trg_hit;
      evt[BIT_TXTRG]   = tx_pop_ok && (32'(tx_cnt) <= HALF + 1);
      evt[BIT_XEND]    = xfer_end_i;
      evt[BIT_TXEMPTY] = tx_done_i && tx_empty_o;
      evt[BIT_OVF]     = rx_push_i && rx_full;
      evt[BIT_UNF]     = tx_pop_i && tx_empty_o;
    end
  end

  assign w1c = wr_stat ? (wdata_i[STAT_W-1:0] & STAT_MASK) : '0;

  spi_fi_irq u_irq (
    .clk_i, .rst_ni, .clr_all_i(srst), .evt_i(evt), .w1c_i(w1c),
    .en_i(ctrl_q[STAT_W-1:0]), .stat_o(stat), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL:  rdata_o = ctrl_q;
      REG_STAT:  begin
        rdata_o = 32'(stat);
        rdata_o[BIT_BUSY] = busy_i && !srst;
      end
      REG_RXLVL: rdata_o = 32'(rx_cnt);
      REG_TXLVL: rdata_o = 32'(tx_cnt);
      REG_RXWIN: rdata_o = rx_empty ? '0 : 32'(rx_head);
      REG_TRIG:  rdata_o = {29'd0, trig_q};
      default:   rdata_o = '0;
    endcase
  end

  a_r1_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && rx_full && !srst |=> stat[BIT_OVF]);
  a_r5_underrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i && tx_empty_o && !srst |=> stat[BIT_UNF] && tx_empty_o);
  a_r9_srst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> stat == '0 && rx_empty && tx_empty_o);
  a_r3_no_trig_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[BIT_RXTEN] && !srst && !$past(stat[BIT_RXTRG]) && !wr_stat
      |=> !stat[BIT_RXTRG]);
  a_r6_trig_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_ok && !srst && !tx_flush && !wr_txwin && tx_cnt <= CW'(HALF + 1)
      |=> stat[BIT_TXTRG] && 32'(tx_cnt) <= HALF);
endmodule

// File: tb/spi_fifo_irq_test.sv
module spi_fifo_irq_test;
  localparam int W = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 0, re = 0, tx_pop = 0, tx_done = 0, rx_push = 0, xfer_end = 0, busy = 0;
  logic [2:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [W-1:0] rx_word = '0;
  logic [31:0]  rdata;
  logic [W-1:0] tx_word;
  logic tx_empty, core_hold, irq;

  always #10 clk = ~clk;

  spi_fifo_irq #(.W(W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_pop_i(tx_pop), .tx_word_o(tx_word), .tx_empty_o(tx_empty),
    .tx_done_i(tx_done), .rx_push_i(rx_push), .rx_word_i(rx_word), .xfer_end_i(xfer_end),
    .busy_i(busy), .core_hold_o(core_hold), .irq_o(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  string phase = "R11";

  logic [W-1:0] rxq[$], txq[$];
  logic [31:0]  m_ctrl = '0;
  logic [13:0]  m_stat = '0;
  logic [2:0]   m_trig = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = m_ctrl;
      3'd1: begin v = 32'(m_stat); v[16] = busy && !m_ctrl[28]; end
      3'd2: v = 32'(rxq.size());
      3'd3: v = 32'(txq.size());
      3'd4: v = (rxq.size() == 0) ? '0 : 32'(rxq[0]);
      3'd6: v = {29'd0, m_trig};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_update();
    bit srst = m_ctrl[28];
    logic [13:0] ev = '0;
    int rxn = rxq.size(), txn = txq.size();
    if (!srst) begin
      ev[0]  = m_ctrl[19] && (rxn >= (1 << m_trig));
      ev[4]  = tx_pop && txn > 0 && txn <= DEPTH / 2 + 1;
      ev[8]  = xfer_end;
      ev[9]  = tx_done && txn == 0;
      ev[12] = rx_push && rxn == DEPTH;
      ev[13] = tx_pop && txn == 0;
    end
    if (srst) m_stat = '0;
    else m_stat = ((m_stat & ~((we && addr == 3'd1) ? wdata[13:0] : 14'd0)) | ev) & 14'h3311;
    if (srst || (we && addr == 3'd2 && wdata == 0)) rxq.delete();
    else begin
      if (re && addr == 3'd4 && rxn > 0) void'(rxq.pop_front());
      if (rx_push && rxn < DEPTH) rxq.push_back(rx_word);
    end
    if (srst || (we && addr == 3'd3 && wdata == 0)) txq.delete();
    else begin
      if (tx_pop && txn > 0) void'(txq.pop_front());
      if (we && addr == 3'd5 && txn < DEPTH) txq.push_back(wdata[W-1:0]);
    end
    if (we && addr == 3'd0) m_ctrl = wdata & 32'h1008_3311;
    if (we && addr == 3'd6) m_trig = wdata[2:0];
  endtask

  task automatic cmp_outputs();
    chk("irq_o", 32'(irq), 32'(|(m_stat & m_ctrl[13:0])));
    chk("tx_empty_o", 32'(tx_empty), 32'(txq.size() == 0));
    chk("core_hold_o", 32'(core_hold), 32'(m_ctrl[28]));
    if (txq.size() > 0) chk("tx_word_o", 32'(tx_word), 32'(txq[0]));
  endtask

  task automatic step();
    #1;
    if (re) chk($sformatf("read addr %0d", addr), rdata, exp_read(addr));
    @(posedge clk);
    model_update();
    #2;
    cmp_outputs();
    we = 0; re = 0; tx_pop = 0; tx_done = 0; rx_push = 0; xfer_end = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; step();
  endtask
  task automatic rd(input logic [2:0] a);
    re = 1; addr = a; step();
  endtask
  task automatic epush(input logic [W-1:0] d);
    rx_push = 1; rx_word = d; step();
  endtask
  task automatic epop();
    tx_pop = 1; step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #5 rst_n = 1;
    phase = "R11";
    cmp_outputs();
    for (int a = 0; a < 7; a++) rd(3'(a));

    phase = "R10";
    wr(3'd5, 32'h1111); wr(3'd5, 32'h2222); wr(3'd5, 32'h3333);
    rd(3'd3);
    we = 1; addr = 3'd5; wdata = 32'h4444; tx_pop = 1; step();
    rd(3'd3);
    phase = "R6";
    epop(); epop(); epop();
    rd(3'd1);
    phase = "R5";
    epop(); epop();
    rd(3'd1); rd(3'd3);
    phase = "R7";
    tx_done = 1; step();
    xfer_end = 1; step();
    rd(3'd1);
    phase = "R4";
    wr(3'd1, 32'h0000_0011);
    rd(3'd1);
    wr(3'd1, 32'h0);
    rd(3'd1);
    xfer_end = 1; we = 1; addr = 3'd1; wdata = 32'h100; step();
    rd(3'd1);
    phase = "R8";
    wr(3'd0, 32'h0000_2000);
    rd(3'd0);
    wr(3'd1, 32'h2000);
    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'h3311);
    rd(3'd1);

    phase = "R6";
    for (int i = 0; i < 20; i++) wr(3'd5, 32'(16'hB000 + i));
    rd(3'd3);
    wr(3'd1, 32'h3311);
    epop(); epop(); rd(3'd1);
    epop(); rd(3'd1);
    epop(); rd(3'd1);
    phase = "R2";
    wr(3'd3, 32'd7); rd(3'd3);
    wr(3'd3, 32'd0); rd(3'd3);

    phase = "R1";
    for (int i = 0; i < DEPTH + 1; i++) epush(16'hA000 + 16'(i));
    rd(3'd2); rd(3'd1);
    phase = "R10";
    rd(3'd4); rd(3'd4); rd(3'd2);
    phase = "R2";
    wr(3'd2, 32'd5); rd(3'd2);
    wr(3'd2, 32'd0); rd(3'd2);
    phase = "R10";
    rd(3'd4);

    phase = "R3";
    wr(3'd1, 32'h3311);
    wr(3'd6, 32'd2); rd(3'd6);
    for (int i = 0; i < 4; i++) epush(16'hC000 + 16'(i));
    rd(3'd1);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0008_0001);
    epush(16'h1); epush(16'h2); epush(16'h3);
    rd(3'd1);
    epush(16'h4);
    idle_cycle();
    rd(3'd1);
    wr(3'd6, 32'd7); wr(3'd1, 32'h1); idle_cycle(); rd(3'd1);

    phase = "R9";
    wr(3'd5, 32'h55); xfer_end = 1; step();
    busy = 1; rd(3'd1);
    wr(3'd0, 32'h1000_0000);
    idle_cycle();
    rd(3'd1); rd(3'd2); rd(3'd3);
    epush(16'h77); wr(3'd5, 32'h66); epop();
    rd(3'd2); rd(3'd3); rd(3'd1);
    wr(3'd0, 32'h0);
    rd(3'd1); rd(3'd2);
    busy = 0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic idle_cycle();
    step();
  endtask
endmodule